// File: doc/BRIEF.md
# Event Timestamp Capture Unit

This block stamps external events with the value of a free-running 16-bit counter. The event source is either a device pin or a comparator output, chosen by a select input. The chosen signal is synchronized and can optionally be debounced. An edge detector then picks out rising or falling transitions. On each qualifying transition the block copies the counter value, which arrives as an input, into a 16-bit capture register and raises a capture flag. The flag can drive an interrupt request.

A processor reaches the capture register over an 8-bit bus through a shared temporary high-byte register. Reading the low byte latches the high byte, so a 16-bit value read in two steps is always consistent. When the waveform mode input says the register sets the counter's TOP value, software may write it: the high byte is written first and held, and the low-byte write commits both bytes together.

Top module: `evt_stamp`

## Requirements
- R1: After reset the capture register, the temporary register and the flag are zero, so reads of addresses 0, 1 and 2 return 0 and `irq` is low.
- R2: With the debounce filter off, a qualifying change of the selected input, applied before clock edge k, stores the `cnt_val` present at edge k+2 into the capture register. The flag (address 2, bit 0) is set on that same edge.
- R3: With `edge_rise`=1 only 0-to-1 changes capture. With `edge_rise`=0 only 1-to-0 changes capture. The opposite change leaves the flag and the register untouched.
- R4: With `src_cmp`=1 the event comes from `cmp_in` and `pin_in` is ignored. With `src_cmp`=0 the event comes from `pin_in` and `cmp_in` is ignored.
- R5: With `filt_en`=1 a level is accepted only after four consecutive equal synchronized samples. A capture is then four cycles later than in R2, and a pulse shorter than four cycles causes no capture.
- R6: `irq` is high exactly when the flag is set and `ie`=1.
- R7: A one-cycle `int_ack` clears the flag. A bus write to address 2 with data bit 0 = 1 clears it too, and a write there with bit 0 = 0 has no effect.
- R8: A read of address 0 returns the low byte and copies the high byte into the temporary register. A read of address 1 returns the temporary register, even if a capture has since changed the capture register.
- R9: With `top_mode`=1, a write to address 1 loads the temporary register, and a following write to address 0 stores {temporary, data} into the capture register. With `top_mode`=0 both writes are ignored.
- R10: A capture while the flag is already set overwrites the register with the newer value, and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_val | input | 16 | Free-running counter value |
| pin_in | input | 1 | Asynchronous external event pin |
| cmp_in | input | 1 | Comparator output event source |
| src_cmp | input | 1 | 1 selects `cmp_in`, 0 selects `pin_in` |
| edge_rise | input | 1 | 1 captures rising changes, 0 captures falling changes |
| filt_en | input | 1 | Enables the four-sample debounce filter |
| ie | input | 1 | Interrupt enable |
| int_ack | input | 1 | Interrupt serviced; clears the flag |
| top_mode | input | 1 | Waveform mode uses the capture register as TOP; enables writes |
| addr | input | 2 | Bus address: 0 low byte, 1 high byte (temporary), 2 flag |
| rd_en | input | 1 | Bus read strobe |
| wr_en | input | 1 | Bus write strobe |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Bus read data, combinational from `addr` |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `rd_en` and `wr_en` are never high in the same cycle. They also assume that `src_cmp`, `edge_rise` and `filt_en` change only while the input being switched to sits at the same settled level as the one currently used, so no event appears from the switch alone. The stimulus changes these controls only after long idle gaps with both sources low. It holds every bus strobe for exactly one cycle. Event inputs change on the falling clock edge and stay put for at least ten cycles, except for the one deliberately short pulse that tests the filter.

// File: rtl/evt_stamp.sv
module evt_stamp #(
  parameter int BW = 8,
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2*BW-1:0] cnt_val,
  input  logic          pin_in,
  input  logic          cmp_in,
  input  logic          src_cmp,
  input  logic          edge_rise,
  input  logic          filt_en,
  input  logic          ie,
  input  logic          int_ack,
  input  logic          top_mode,
  input  logic [1:0]    addr,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [BW-1:0] wdata,
  output logic [BW-1:0] rdata,
  output logic          irq
);
  localparam int CW = 2 * BW;

  logic [1:0]    sync_q;
  logic [NF-2:0] hist_q;
  logic          filt_q, lvl_q, flag_q;
  logic [CW-1:0] cap_q;
  logic [BW-1:0] tmp_q;

  wire          src_raw = src_cmp ? cmp_in : pin_in;
  wire          s       = sync_q[1];
  wire [NF-1:0] window  = {hist_q, s};
  wire          lvl     = filt_en ? filt_q : s;
  wire          evt     = (lvl != lvl_q) && (lvl == edge_rise);

  wire rd_lo = rd_en && addr == 2'd0;
  wire wr_hi = wr_en && addr == 2'd1 && top_mode;
  wire wr_lo = wr_en && addr == 2'd0 && top_mode;
  wire clr   = int_ack || (wr_en && addr == 2'd2 && wdata[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= '0;
      filt_q <= 1'b0;
      lvl_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], src_raw};
      hist_q <= window[NF-2:0];
      if (&window)       filt_q <= 1'b1;
      else if (~|window) filt_q <= 1'b0;
      lvl_q <= lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '0;
      tmp_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (evt)        cap_q <= cnt_val;
      else if (wr_lo) cap_q <= {tmp_q, wdata};
      if (rd_lo)      tmp_q <= cap_q[CW-1:BW];
      else if (wr_hi) tmp_q <= wdata;
      if (evt)        flag_q <= 1'b1;
      else if (clr)   flag_q <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = cap_q[BW-1:0];
      2'd1:    rdata = tmp_q;
      2'd2:    rdata = {{(BW-1){1'b0}}, flag_q};
      default: rdata = '0;
    endcase
  end

  assign irq = flag_q & ie;
endmodule

// File: rtl/evt_stamp_chk.sv
module evt_stamp_chk #(
  parameter int BW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2*BW-1:0] cnt_val,
  input logic            ie,
  input logic            int_ack,
  input logic            top_mode,
  input logic [1:0]      addr,
  input logic            rd_en,
  input logic            wr_en,
  input logic [BW-1:0]   wdata,
  input logic            irq,
  input logic            evt,
  input logic            flag_q,
  input logic [2*BW-1:0] cap_q,
  input logic [BW-1:0]   tmp_q
);
  assert_cap_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (flag_q && cap_q == $past(cnt_val)));

  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie || !flag_q) |-> !irq);

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && !evt) |=> !flag_q);

  assert_temp_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd0) |=> (tmp_q == $past(cap_q[2*BW-1:BW])));

  assert_write_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !top_mode && !evt) |=> $stable(cap_q));

  assert_flag_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !int_ack && !(wr_en && addr == 2'd2 && wdata[0])) |=> flag_q);
endmodule

bind evt_stamp evt_stamp_chk #(.BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .ie(ie), .int_ack(int_ack),
  .top_mode(top_mode), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
  .wdata(wdata), .irq(irq), .evt(evt), .flag_q(flag_q), .cap_q(cap_q),
  .tmp_q(tmp_q)
);

// File: tb/tb_evt_stamp.sv
module tb_evt_stamp;
  localparam logic [15:0] STEP = 16'h0111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] cnt_val = '0;
  logic pin_in = 0, cmp_in = 0, src_cmp = 0, edge_rise = 1, filt_en = 0;
  logic ie = 0, int_ack = 0, top_mode = 0, rd_en = 0, wr_en = 0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq;

  int checks = 0, errors = 0;
  logic [15:0] exp_q[$], obs_q[$];
  string tag_q[$];
  logic [15:0] last_exp;

  evt_stamp dut (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .pin_in(pin_in),
    .cmp_in(cmp_in), .src_cmp(src_cmp), .edge_rise(edge_rise),
    .filt_en(filt_en), .ie(ie), .int_ack(int_ack), .top_mode(top_mode),
    .addr(addr), .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .irq(irq)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cnt_val <= cnt_val + STEP;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1;
    #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic drive_edge(input bit use_cmp, input bit val, input int lat,
                            input bit push, input string tag);
    @(negedge clk);
    if (use_cmp) cmp_in = val; else pin_in = val;
    last_exp = 16'(cnt_val + 16'(lat) * STEP);
    if (push) begin exp_q.push_back(last_exp); tag_q.push_back(tag); end
    repeat (10) @(negedge clk);
  endtask

  task automatic fetch();
    logic [7:0] lo, hi;
    bus_rd(2'd0, lo);
    bus_rd(2'd1, hi);
    obs_q.push_back({hi, lo});
  endtask

  task automatic flag_is(input bit e, input string tag);
    logic [7:0] d;
    bus_rd(2'd2, d);
    chk(d == {7'd0, e}, tag, d, e);
  endtask

  always @(negedge clk) begin
    while (exp_q.size() > 0 && obs_q.size() > 0) begin
      logic [15:0] e, o;
      string t;
      e = exp_q.pop_front(); o = obs_q.pop_front(); t = tag_q.pop_front();
      chk(o == e, t, o, e);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d, d2;
    logic [15:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    bus_rd(2'd0, d); chk(d == 0, "R1 low", d, 0);
    bus_rd(2'd1, d); chk(d == 0, "R1 high", d, 0);
    flag_is(0, "R1 flag");
    chk(irq == 0, "R1 irq", irq, 0);

    // R2 rising capture on pin
    drive_edge(0, 1, 2, 1, "R2 value");
    fetch();
    flag_is(1, "R2 flag");

    // R6 interrupt gating
    @(negedge clk) ie = 1; #1 chk(irq == 1, "R6 irq on", irq, 1);
    @(negedge clk) ie = 0; #1 chk(irq == 0, "R6 irq off", irq, 0);

    // R7 software clear
    bus_wr(2'd2, 8'h00); flag_is(1, "R7 write0 ignored");
    bus_wr(2'd2, 8'h01); flag_is(0, "R7 write1 clears");

    // R3 edge polarity
    drive_edge(0, 0, 2, 0, "");
    flag_is(0, "R3 falling ignored");
    @(negedge clk) edge_rise = 0;
    drive_edge(0, 1, 2, 0, "");
    flag_is(0, "R3 rising ignored");
    drive_edge(0, 0, 2, 1, "R3 falling value");
    fetch();
    @(negedge clk) int_ack = 1;
    @(negedge clk) int_ack = 0;
    flag_is(0, "R7 ack clears");
    @(negedge clk) edge_rise = 1;

    // R4 source select
    @(negedge clk) src_cmp = 1;
    drive_edge(0, 1, 2, 0, "");
    flag_is(0, "R4 pin ignored");
    drive_edge(1, 1, 2, 1, "R4 cmp value");
    fetch();
    drive_edge(1, 0, 2, 0, "");
    drive_edge(0, 0, 2, 0, "");
    @(negedge clk) src_cmp = 0;
    drive_edge(1, 1, 2, 0, "");
    flag_is(1, "R4 cmp ignored under pin select");
    drive_edge(1, 0, 2, 0, "");
    bus_wr(2'd2, 8'h01);

    // R5 filter
    @(negedge clk) filt_en = 1;
    @(negedge clk) pin_in = 1;
    repeat (2) @(negedge clk);
    pin_in = 0;
    repeat (12) @(negedge clk);
    flag_is(0, "R5 short pulse rejected");
    drive_edge(0, 1, 6, 1, "R5 filtered value");
    fetch();
    drive_edge(0, 0, 6, 0, "");
    repeat (8) @(negedge clk);
    @(negedge clk) filt_en = 0;
    bus_wr(2'd2, 8'h01);

    // R10 overwrite while flag set
    drive_edge(0, 1, 2, 0, "");
    drive_edge(0, 0, 2, 0, "");
    drive_edge(0, 1, 2, 1, "R10 newer value");
    fetch();
    flag_is(1, "R10 flag kept");

    // R8 consistent two-step read
    v = last_exp;
    bus_rd(2'd0, d);
    chk(d == v[7:0], "R8 low", d, v[7:0]);
    drive_edge(0, 0, 2, 0, "");
    drive_edge(0, 1, 2, 0, "");
    bus_rd(2'd1, d);
    chk(d == v[15:8], "R8 high from temp", d, v[15:8]);
    exp_q.push_back(last_exp); tag_q.push_back("R8 new value");
    fetch();

    // R9 write locking and commit
    v = last_exp;
    bus_wr(2'd1, 8'hAB); bus_wr(2'd0, 8'hCD);
    bus_rd(2'd0, d); bus_rd(2'd1, d2);
    chk({d2, d} == v, "R9 locked", {d2, d}, v);
    @(negedge clk) top_mode = 1;
    bus_wr(2'd1, 8'hAB); bus_wr(2'd0, 8'hCD);
    bus_rd(2'd0, d); bus_rd(2'd1, d2);
    chk({d2, d} == 16'hABCD, "R9 commit", {d2, d}, 16'hABCD);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule